// File: doc/BRIEF.md
# UART Interrupt Cause and Status Register

This block collects the interrupt sources of a buffered UART into a single 32-bit status word and drives one interrupt line toward the host. Each source has its own sticky pending-cause bit, so any number of causes can be pending at once. The host clears causes selectively with a byte write, and no priority encoding is applied. The same word carries several other fields side by side:

- the four modem input levels, each with a change flag;
- the line status byte supplied by the receiver;
- the ten-bit receive fill count, split between the top byte and two spare bits of the low byte.

A second word, the configuration, holds four per-source interrupt enables, a line-format byte that a neighbouring shifter decodes, and six modem control outputs. The serial shifter and the FIFO data path sit outside this block. All of its pins are plain control and status signals, so there is no valid/ready stream at its edge. Host writes are single-cycle strobes that are never stalled. Status and configuration are visible continuously on output buses, which a read multiplexer elsewhere selects.

Top module: `uart_irq_status`

## Requirements
- R1: Status bits [4:0] are sticky cause bits: bit 0 line status (`ev_line_i`), bit 1 receive data (`ev_rx_i`), bit 2 character timeout (`ev_tmo_i`), bit 3 transmit space (`ev_txsp_i`), bit 4 modem change (any modem edge). A one-cycle event pulse sets its bit from the next cycle on, and the bit stays set until it is acknowledged. Status bit 5 reads 0.
- R2: A write with `wr_addr_i`=0 and `wr_be_i[0]`=1 clears exactly the cause bits whose `wr_data_i[4:0]` bit is 1, one cycle later. All other cause bits keep their value.
- R3: When a cause event and an acknowledge of the same bit fall in one cycle, the bit stays set.
- R4: Writes to offset 0 have no effect on status bits [7:6] or on any status byte other than byte 0. A write to offset 0 with `wr_be_i[0]`=0 clears nothing.
- R5: Status bits [15:12] give the levels of CTS, DSR, RI and DCD (bit 12 = CTS) after two synchroniser stages. Bits [11:8] are the matching change flags. A flag sets one cycle after its level bit changes and clears only when cause bit 4 is acknowledged. An edge arriving in the acknowledge cycle keeps its flag set.
- R6: Status bits [23:16] mirror `lsr_i` combinationally. Bits [31:24] carry `rxcnt_i[7:0]`, and bits [7:6] carry `rxcnt_i[9:8]`.
- R7: `irq_o` is high exactly when a cause bit is set together with its enable. The enables are: configuration bit 0 for cause bits 1 and 2, bit 1 for cause bit 3, bit 2 for cause bit 0, and bit 3 for cause bit 4.
- R8: A write to offset `CFG_OFF` (default 4) updates each configuration byte whose byte enable is set, one cycle later. Only bits [3:0], [15:8] and [29:24] are stored; all other bits read 0. Bits 24 to 29 drive `dtr_o`, `rts_o`, `out1_o`, `out2_o`, `loop_o` and `afc_o`, in that order.
- R9: After reset, all cause bits, change flags, synchroniser stages and configuration bits are 0, and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | AW | Byte offset of the write |
| wr_data_i | input | 32 | Write data |
| wr_be_i | input | 4 | Byte enables |
| ev_line_i | input | 1 | Line status event pulse |
| ev_rx_i | input | 1 | Receive data available pulse |
| ev_tmo_i | input | 1 | Character timeout pulse |
| ev_txsp_i | input | 1 | Transmit space available pulse |
| cts_i | input | 1 | Asynchronous CTS level |
| dsr_i | input | 1 | Asynchronous DSR level |
| ri_i | input | 1 | Asynchronous RI level |
| dcd_i | input | 1 | Asynchronous DCD level |
| lsr_i | input | 8 | Line status byte from the receiver |
| rxcnt_i | input | 10 | Receive FIFO fill count |
| stat_o | output | 32 | Status word |
| cfg_o | output | 32 | Configuration word |
| irq_o | output | 1 | Interrupt request |
| dtr_o | output | 1 | DTR output |
| rts_o | output | 1 | RTS output |
| out1_o | output | 1 | General output 1 |
| out2_o | output | 1 | General output 2 |
| loop_o | output | 1 | Loopback enable |
| afc_o | output | 1 | Automatic RTS/CTS flow control enable |

## Verification
The assertions assume the event inputs are sampled as one-cycle pulses, so a level held high simply keeps re-setting its cause. They also assume host writes are single-cycle strobes, with address and byte enables valid whenever `wr_en_i` is high. The modem lines are taken as asynchronous, but they are held low through reset so that the first comparison does not see a spurious edge. The stimulus respects all of this while still forcing events and acknowledges into the same cycle. It also writes to the upper status bytes and to an unmapped offset, and toggles modem lines back-to-back so that edges land inside an acknowledge cycle.

// File: rtl/uic_pkg.sv
package uic_pkg;
  localparam int NUM_CAUSE = 5;
  localparam int NUM_MODEM = 4;
  localparam int C_LINE    = 0;
  localparam int C_RX      = 1;
  localparam int C_TMO     = 2;
  localparam int C_TXSP    = 3;
  localparam int C_MODEM   = 4;
  localparam int EN_RX     = 0;
  localparam int EN_TXSP   = 1;
  localparam int EN_LINE   = 2;
  localparam int EN_MODEM  = 3;
  localparam int MC_BASE   = 24;
  localparam logic [31:0] CFG_WMASK = 32'h3F00_FF0F;
endpackage

// File: rtl/uic_modem_sync.sv
module uic_modem_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] edge_o
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic [STAGES:0] sh_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-1:0], async_i[i]};
    end
    assign lvl_o[i]  = sh_q[STAGES-1];
    assign edge_o[i] = sh_q[STAGES-1] ^ sh_q[STAGES];
  end
endmodule

// File: rtl/uic_sticky.sv
module uic_sticky #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q_o[i] <= 1'b0;
      else if (set_i[i]) q_o[i] <= 1'b1;
      else if (clr_i[i]) q_o[i] <= 1'b0;
    end

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (q_o[i] && !clr_i[i]) |=> q_o[i]); // R1
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> q_o[i]); // R3
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !set_i[i]) |=> !q_o[i]); // R2
  end
endmodule

// File: rtl/uic_cfg_reg.sv
module uic_cfg_reg #(
  parameter int          W     = 32,
  parameter logic [W-1:0] WMASK = '1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_i,
  input  logic [W-1:0]   data_i,
  input  logic [W/8-1:0] be_i,
  output logic [W-1:0]   q_o
);
  localparam int NB = W / 8;
  for (genvar b = 0; b < NB; b++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q_o[b*8 +: 8] <= '0;
      else if (wr_i && be_i[b])
        q_o[b*8 +: 8] <= data_i[b*8 +: 8] & WMASK[b*8 +: 8];
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(q_o)); // R8
  AST_CFG_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o & ~WMASK) == '0); // R8
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
  import uic_pkg::*;
#(
  parameter int AW          = 4,
  parameter int CFG_OFF     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [31:0]   wr_data_i,
  input  logic [3:0]    wr_be_i,
  input  logic          ev_line_i,
  input  logic          ev_rx_i,
  input  logic          ev_tmo_i,
  input  logic          ev_txsp_i,
  input  logic          cts_i,
  input  logic          dsr_i,
  input  logic          ri_i,
  input  logic          dcd_i,
  input  logic [7:0]    lsr_i,
  input  logic [9:0]    rxcnt_i,
  output logic [31:0]   stat_o,
  output logic [31:0]   cfg_o,
  output logic          irq_o,
  output logic          dtr_o,
  output logic          rts_o,
  output logic          out1_o,
  output logic          out2_o,
  output logic          loop_o,
  output logic          afc_o
);
  localparam logic [AW-1:0] STAT_ADDR = '0;
  localparam logic [AW-1:0] CFG_ADDR  = AW'(CFG_OFF);

  logic                 ack_hit, cfg_hit;
  logic [NUM_CAUSE-1:0] ack_clr, cause_set, cause_q, cause_en;
  logic [NUM_MODEM-1:0] mdm_in, mdm_lvl, mdm_edge, delta_q, delta_clr;
  logic [31:0]          cfg_q;

  // host decode: acknowledge touches byte 0 of the status word only
  assign ack_hit = wr_en_i && (wr_addr_i == STAT_ADDR) && wr_be_i[0];
  assign ack_clr = ack_hit ? wr_data_i[NUM_CAUSE-1:0] : '0;
  assign cfg_hit = wr_en_i && (wr_addr_i == CFG_ADDR);

  assign mdm_in = {dcd_i, ri_i, dsr_i, cts_i};

  uic_modem_sync #(.N(NUM_MODEM), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(mdm_in),
    .lvl_o(mdm_lvl), .edge_o(mdm_edge)
  );

  // change flags are dropped together with the modem cause acknowledge
  assign delta_clr = {NUM_MODEM{ack_clr[C_MODEM]}};

  uic_sticky #(.W(NUM_MODEM)) u_delta (
    .clk(clk), .rst_n(rst_n), .set_i(mdm_edge), .clr_i(delta_clr), .q_o(delta_q)
  );

  always_comb begin
    cause_set          = '0;
    cause_set[C_LINE]  = ev_line_i;
    cause_set[C_RX]    = ev_rx_i;
    cause_set[C_TMO]   = ev_tmo_i;
    cause_set[C_TXSP]  = ev_txsp_i;
    cause_set[C_MODEM] = |mdm_edge;
  end

  uic_sticky #(.W(NUM_CAUSE)) u_cause (
    .clk(clk), .rst_n(rst_n), .set_i(cause_set), .clr_i(ack_clr), .q_o(cause_q)
  );

  uic_cfg_reg #(.W(32), .WMASK(CFG_WMASK)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_i(cfg_hit), .data_i(wr_data_i),
    .be_i(wr_be_i), .q_o(cfg_q)
  );

  always_comb begin
    cause_en          = '0;
    cause_en[C_LINE]  = cfg_q[EN_LINE];
    cause_en[C_RX]    = cfg_q[EN_RX];
    cause_en[C_TMO]   = cfg_q[EN_RX];
    cause_en[C_TXSP]  = cfg_q[EN_TXSP];
    cause_en[C_MODEM] = cfg_q[EN_MODEM];
  end

  assign irq_o  = |(cause_q & cause_en);
  assign stat_o = {rxcnt_i[7:0], lsr_i, mdm_lvl, delta_q, rxcnt_i[9:8], 1'b0, cause_q};
  assign cfg_o  = cfg_q;
  assign dtr_o  = cfg_q[MC_BASE + 0];
  assign rts_o  = cfg_q[MC_BASE + 1];
  assign out1_o = cfg_q[MC_BASE + 2];
  assign out2_o = cfg_q[MC_BASE + 3];
  assign loop_o = cfg_q[MC_BASE + 4];
  assign afc_o  = cfg_q[MC_BASE + 5];

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_o[4:0] == '0) |-> !irq_o); // R7
  AST_DELTA_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_o[11:8] != '0) |-> stat_o[4]); // R5
  AST_LEVEL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_o[15:12] != $past(stat_o[15:12])) |=> ((stat_o[11:8] & ($past(stat_o[15:12]) ^ $past(stat_o[15:12], 2))) == ($past(stat_o[15:12]) ^ $past(stat_o[15:12], 2)))); // R5
endmodule

// File: tb/uart_irq_status_tb_top.sv
`timescale 1ns/1ps
module uart_irq_status_tb_top;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0; logic [3:0] wr_addr = 0; logic [31:0] wr_data = 0; logic [3:0] wr_be = 0;
  logic ev_line = 0, ev_rx = 0, ev_tmo = 0, ev_txsp = 0;
  logic cts = 0, dsr = 0, ri = 0, dcd = 0;
  logic [7:0] lsr = 0; logic [9:0] rxcnt = 0;
  logic [31:0] stat, cfg; logic irq, dtr, rts, out1, out2, loopb, afc;
  int total = 0, bad = 0; bit done = 0, cmp_on = 0;

  always #4 clk = ~clk;

  uart_irq_status dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .wr_be_i(wr_be), .ev_line_i(ev_line), .ev_rx_i(ev_rx), .ev_tmo_i(ev_tmo),
    .ev_txsp_i(ev_txsp), .cts_i(cts), .dsr_i(dsr), .ri_i(ri), .dcd_i(dcd), .lsr_i(lsr),
    .rxcnt_i(rxcnt), .stat_o(stat), .cfg_o(cfg), .irq_o(irq), .dtr_o(dtr), .rts_o(rts),
    .out1_o(out1), .out2_o(out2), .loop_o(loopb), .afc_o(afc));

  // behavioural reference model
  int m_cause, m_delta, m_s1, m_s2, m_s3, m_cfg;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cause = 0; m_delta = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_cfg = 0;
    end else begin
      int edges, clr, setv;
      edges = (m_s2 ^ m_s3) & 15;
      clr = (wr_en && wr_addr == 0 && wr_be[0]) ? int'(wr_data[4:0]) : 0;
      setv = (ev_line ? 1 : 0) + (ev_rx ? 2 : 0) + (ev_tmo ? 4 : 0) + (ev_txsp ? 8 : 0)
           + ((edges != 0) ? 16 : 0);
      m_cause = (m_cause & ~clr) | setv;
      m_delta = (((clr & 16) != 0) ? 0 : m_delta) | edges;
      m_s3 = m_s2; m_s2 = m_s1;
      m_s1 = (cts ? 1 : 0) + (dsr ? 2 : 0) + (ri ? 4 : 0) + (dcd ? 8 : 0);
      if (wr_en && wr_addr == 4)
        for (int b = 0; b < 4; b++)
          if (wr_be[b]) m_cfg = (m_cfg & ~(255 << (8*b))) | (int'(wr_data[8*b +: 8]) << (8*b));
      m_cfg = m_cfg & 32'h3F00_FF0F;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    logic [31:0] es; logic [4:0] en; logic ei;
    es = {rxcnt[7:0], lsr, 4'(m_s2), 4'(m_delta), rxcnt[9:8], 1'b0, 5'(m_cause)};
    en = {m_cfg[3], m_cfg[1], m_cfg[0], m_cfg[0], m_cfg[2]};
    ei = |(5'(m_cause) & en);
    chk("R1/R2 cause bits", {27'd0, stat[4:0]}, {27'd0, es[4:0]});
    chk("R5 modem byte", {24'd0, stat[15:8]}, {24'd0, es[15:8]});
    chk("R6 lsr and fill count", {stat[31:16], 8'd0, stat[7:6], 6'd0}, {es[31:16], 8'd0, es[7:6], 6'd0});
    chk("R7 irq", {31'd0, irq}, {31'd0, ei});
    chk("R8 config", cfg, m_cfg);
    chk("R8 modem outputs", {26'd0, afc, loopb, out2, out1, rts, dtr}, {26'd0, 6'(m_cfg >> 24)});
  end

  task automatic step(); @(posedge clk); #1; endtask
  task automatic idle();
    wr_en = 0; ev_line = 0; ev_rx = 0; ev_tmo = 0; ev_txsp = 0;
  endtask
  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be);
    wr_en = 1; wr_addr = a; wr_data = d; wr_be = be;
  endtask

  initial begin
    repeat (4) step();
    rst_n = 1; cmp_on = 1;
    @(negedge clk);
    chk("R9 reset status", stat, 32'h0);
    chk("R9 reset config", cfg, 32'h0);
    chk("R9 reset irq", {31'd0, irq}, 32'h0);
    step();
    // enable everything, set all causes, then check irq and partial ack
    wr(4, 32'hFFFF_FFFF, 4'hF); step(); idle();
    ev_line = 1; ev_rx = 1; ev_tmo = 1; ev_txsp = 1; step(); idle();
    @(negedge clk); chk("R1 all causes set", {27'd0, stat[4:0]}, 32'h0F);
    step();
    wr(0, 32'h0000_0005, 4'h1); step(); idle();
    @(negedge clk); chk("R2 partial ack", {27'd0, stat[4:0]}, 32'h0A);
    step();
    // R3: event and ack of the same bit in one cycle
    ev_rx = 1; wr(0, 32'h0000_0002, 4'h1); step(); idle();
    @(negedge clk); chk("R3 event wins", {31'd0, stat[1]}, 32'h1);
    step();
    // R4: upper bytes and bits 7:6 ignored, be0 clear ignored
    wr(0, 32'hFFFF_FFC0, 4'hF); step(); idle();
    @(negedge clk); chk("R4 bits 7:6 write ignored", {27'd0, stat[4:0]}, 32'h0A);
    step();
    wr(0, 32'hFFFF_FFFF, 4'hE); step(); idle();
    @(negedge clk); chk("R4 no be0 no clear", {27'd0, stat[4:0]}, 32'h0A);
    step();
    // R5: modem edge, then ack with a fresh edge in the ack cycle
    cts = 1; repeat (4) step();
    @(negedge clk); chk("R5 cts flag", {28'd0, stat[11:8]}, 32'h1);
    step();
    dsr = 1; step(); step();
    wr(0, 32'h10, 4'h1); step(); idle();
    @(negedge clk); chk("R5 edge in ack cycle kept", {28'd0, stat[11:8]}, 32'h2);
    step();
    wr(0, 32'h1F, 4'h1); step(); idle(); step();
    // R7: per-enable mapping
    wr(4, 32'h0000_0002, 4'h1); step(); idle();
    ev_rx = 1; step(); idle();
    @(negedge clk); chk("R7 rx masked", {31'd0, irq}, 32'h0);
    step();
    ev_txsp = 1; step(); idle();
    @(negedge clk); chk("R7 txsp enabled", {31'd0, irq}, 32'h1);
    step();
    // random phase
    for (int n = 0; n < 3000; n++) begin
      idle();
      ev_line = ($urandom % 8) == 0; ev_rx = ($urandom % 8) == 0;
      ev_tmo = ($urandom % 8) == 0; ev_txsp = ($urandom % 8) == 0;
      if (($urandom % 16) == 0) cts = ~cts;
      if (($urandom % 16) == 0) dsr = ~dsr;
      if (($urandom % 16) == 0) ri = ~ri;
      if (($urandom % 16) == 0) dcd = ~dcd;
      lsr = 8'($urandom); rxcnt = 10'($urandom);
      if (($urandom % 6) == 0) begin
        logic [3:0] a;
        case ($urandom % 3) 0: a = 0; 1: a = 4; default: a = 8; endcase
        wr(a, $urandom, 4'($urandom));
      end
      step();
    end
    idle(); step();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule